// File: doc/BRIEF.md
# Node Identity and Wake-Up Gate

This block keeps the two identity registers of a token-passing network node and decides when the rest of the node may run. Software reaches the registers through a small sub-address window. A write puts a value in the node-ID register or in the tentative-ID register. A read returns either register or a diagnostic byte. The stored node ID drives three activity outputs. While the node ID is zero the node core is held dormant. It executes nothing, passes no tokens and causes no reconfigurations. When a non-zero node ID is stored, the core wakes and receive monitoring starts. The node does not transmit onto the network until the transmit-enable configuration input is also high.

The tentative-ID register supports building a map of the network while the node is running. Software loads a candidate station number and then polls the diagnostic byte. A flag in that byte reports whether traffic carrying the candidate as its source has been seen. The node's own logical successor cannot be found this way. Its number is supplied on a separate input, and traffic from that source never sets the flag.

Top module: `node_wake_gate`

## Requirements
- R1: After hardware reset (rst_n low), the node-ID and tentative-ID registers read 8'h00, the seen flag reads 0, and core_en, tx_join and rx_mon_en are all 0.
- R2: A write with cfg_sel=2'd0 loads cfg_wdata into the node-ID register, and a write with cfg_sel=2'd1 loads it into the tentative-ID register. Each takes effect on the clock edge that captures the write. A read with cfg_sel=0 or 1 returns that register on cfg_rdata in the same cycle. A write to any other sub-address changes neither register.
- R3: core_en is 1 exactly when the stored node ID is non-zero. It changes on the clock edge that captures the node-ID write.
- R4: tx_join is 1 only when core_en is 1 and tx_enable is 1, and it follows tx_enable in the same cycle.
- R5: rx_mon_en equals core_en whatever the value of tx_enable, so receive monitoring runs with the transmitter off.
- R6: The seen flag is bit 0 of the diagnostic byte, read with cfg_sel=2'd2, and bits 7..1 read 0. The flag sets on the clock edge after a cycle in which all of these hold: mon_valid=1, core_en=1, mon_src_id equals the tentative ID, the tentative ID is non-zero, and mon_src_id differs from succ_id.
- R7: A tentative-ID write clears the flag, even if a matching observation arrives in the same cycle. A diagnostic read clears the flag after returning its value, unless a matching observation arrives in that same cycle, in which case the flag stays set.
- R8: An observation whose source equals succ_id never sets the flag, even when it matches the tentative ID.
- R9: Writing node ID 8'h00 while awake drops core_en, tx_join and rx_mon_en on the edge that captures the write, and the tentative-ID register keeps its value.
- R10: cfg_rdata is 0 when cfg_rd is 0, and it is 0 for a read with cfg_sel=2'd3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_sel | input | 2 | Sub-address: 0 node ID, 1 tentative ID, 2 diagnostic, 3 unused |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data, combinational from cfg_sel |
| tx_enable | input | 1 | Transmit-enable configuration bit |
| mon_valid | input | 1 | A token or frame source ID is being observed |
| mon_src_id | input | 8 | Source ID of the observed traffic |
| succ_id | input | 8 | ID of this node's logical successor |
| node_id | output | 8 | Stored node ID for the core |
| core_en | output | 1 | Core is awake |
| tx_join | output | 1 | Node may join the network and transmit |
| rx_mon_en | output | 1 | Receive monitoring active |

## Verification
The assertions assume that cfg_wr and cfg_rd are never high together. They also assume at most one observation per cycle, and that the strobes are clean at the clock edge. The bench keeps to these assumptions by driving every input on the falling edge and by running each register access as a single-strobe cycle. The bench sweeps all 256 node-ID values and all 256 tentative-ID values. For each tentative value it presents one matching source and one mismatching source. The successor case and the same-cycle clear-versus-set orderings are driven as separate, deliberate cycles.

// File: rtl/nwg_pkg.sv
package nwg_pkg;
  localparam int ID_W  = 8;
  localparam int SEL_W = 2;

  localparam logic [SEL_W-1:0] SEL_NODE = 2'd0;
  localparam logic [SEL_W-1:0] SEL_TENT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_DIAG = 2'd2;

  typedef enum logic [1:0] {
    WK_DORMANT = 2'd0,
    WK_LISTEN  = 2'd1,
    WK_JOINED  = 2'd2
  } wake_state_e;

  function automatic logic id_live(input logic [ID_W-1:0] id);
    return id != '0;
  endfunction

  function automatic logic probe_hit(input logic [ID_W-1:0] src,
                                     input logic [ID_W-1:0] tent,
                                     input logic [ID_W-1:0] succ);
    return (src == tent) && id_live(tent) && (src != succ);
  endfunction
endpackage

// File: rtl/nwg_regs.sv
module nwg_regs
  import nwg_pkg::*;
#(
  parameter int IDW = ID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [SEL_W-1:0] sel,
  input  logic [IDW-1:0]   wdata,
  input  logic             flag,
  output logic [IDW-1:0]   node_q,
  output logic [IDW-1:0]   tent_q,
  output logic             tent_wr_ev,
  output logic             diag_rd_ev,
  output logic [IDW-1:0]   rdata
);
  logic node_wr_ev;

  assign node_wr_ev = wr && (sel == SEL_NODE);
  assign tent_wr_ev = wr && (sel == SEL_TENT);
  assign diag_rd_ev = rd && (sel == SEL_DIAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_q <= '0;
      tent_q <= '0;
    end else begin
      if (node_wr_ev) node_q <= wdata;
      if (tent_wr_ev) tent_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (sel)
        SEL_NODE: rdata = node_q;
        SEL_TENT: rdata = tent_q;
        SEL_DIAG: rdata = {{(IDW-1){1'b0}}, flag};
        default:  rdata = '0;
      endcase
    end
  end

  AST_NODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !node_wr_ev |=> $stable(node_q)); // R2
  AST_TENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tent_wr_ev |=> $stable(tent_q)); // R2
  AST_NODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    node_wr_ev |=> node_q == $past(wdata)); // R2
endmodule

// File: rtl/nwg_wake.sv
module nwg_wake
  import nwg_pkg::*;
#(
  parameter int IDW = ID_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IDW-1:0] node_q,
  input  logic           tx_enable,
  output logic           core_en,
  output logic           tx_join,
  output logic           rx_mon_en
);
  wake_state_e state;

  always_comb begin
    if (!id_live(node_q))   state = WK_DORMANT;
    else if (tx_enable)     state = WK_JOINED;
    else                    state = WK_LISTEN;
  end

  assign core_en   = (state != WK_DORMANT);
  assign rx_mon_en = (state != WK_DORMANT);
  assign tx_join   = (state == WK_JOINED);

  AST_JOIN_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_join |-> (core_en && tx_enable)); // R4
  AST_RX_TRACKS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mon_en == core_en); // R5
endmodule

// File: rtl/nwg_probe.sv
module nwg_probe
  import nwg_pkg::*;
#(
  parameter int IDW = ID_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           awake,
  input  logic           mon_valid,
  input  logic [IDW-1:0] mon_src_id,
  input  logic [IDW-1:0] tent_q,
  input  logic [IDW-1:0] succ_id,
  input  logic           tent_wr_ev,
  input  logic           diag_rd_ev,
  output logic           seen_q
);
  logic hit_ev;

  assign hit_ev = mon_valid && awake && probe_hit(mon_src_id, tent_q, succ_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_q <= 1'b0;
    else if (tent_wr_ev) seen_q <= 1'b0;
    else if (hit_ev)     seen_q <= 1'b1;
    else if (diag_rd_ev) seen_q <= 1'b0;
  end

  AST_TENT_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tent_wr_ev |=> !seen_q); // R7
  AST_SUCC_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && mon_valid && mon_src_id == succ_id) |=> !seen_q); // R8
  AST_ASLEEP_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && !awake) |=> !seen_q); // R6
endmodule

// File: rtl/node_wake_gate.sv
module node_wake_gate
  import nwg_pkg::*;
#(
  parameter int IDW = ID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [IDW-1:0]   cfg_wdata,
  output logic [IDW-1:0]   cfg_rdata,
  input  logic             tx_enable,
  input  logic             mon_valid,
  input  logic [IDW-1:0]   mon_src_id,
  input  logic [IDW-1:0]   succ_id,
  output logic [IDW-1:0]   node_id,
  output logic             core_en,
  output logic             tx_join,
  output logic             rx_mon_en
);
  logic [IDW-1:0] tent_q;
  logic           tent_wr_ev;
  logic           diag_rd_ev;
  logic           seen_q;

  nwg_regs #(.IDW(IDW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .rd(cfg_rd), .sel(cfg_sel),
    .wdata(cfg_wdata), .flag(seen_q), .node_q(node_id), .tent_q(tent_q),
    .tent_wr_ev(tent_wr_ev), .diag_rd_ev(diag_rd_ev), .rdata(cfg_rdata)
  );

  nwg_wake #(.IDW(IDW)) u_wake (
    .clk(clk), .rst_n(rst_n), .node_q(node_id), .tx_enable(tx_enable),
    .core_en(core_en), .tx_join(tx_join), .rx_mon_en(rx_mon_en)
  );

  nwg_probe #(.IDW(IDW)) u_probe (
    .clk(clk), .rst_n(rst_n), .awake(core_en), .mon_valid(mon_valid),
    .mon_src_id(mon_src_id), .tent_q(tent_q), .succ_id(succ_id),
    .tent_wr_ev(tent_wr_ev), .diag_rd_ev(diag_rd_ev), .seen_q(seen_q)
  );

  AST_ZERO_WRITE_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == SEL_NODE && cfg_wdata == '0) |=> (!core_en && !tx_join && !rx_mon_en)); // R9
  AST_LIVE_WRITE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == SEL_NODE && cfg_wdata != '0) |=> core_en); // R3
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |-> cfg_rdata == '0); // R10
  AST_DIAG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_sel == SEL_DIAG) |-> cfg_rdata[IDW-1:1] == '0); // R6
endmodule

// File: tb/tb_node_wake_gate.sv
module tb_node_wake_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       tx_enable = 1'b0, mon_valid = 1'b0;
  logic [7:0] mon_src_id = 8'h00, succ_id = 8'h00;
  logic [7:0] node_id;
  logic       core_en, tx_join, rx_mon_en;
  int         n_run = 0, n_fail = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  node_wake_gate dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_enable(tx_enable), .mon_valid(mon_valid), .mon_src_id(mon_src_id),
    .succ_id(succ_id), .node_id(node_id), .core_en(core_en),
    .tx_join(tx_join), .rx_mon_en(rx_mon_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  function automatic logic [7:0] rd_reg(input logic [1:0] s);
    return 8'h00;
  endfunction

  task automatic read_now(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); cfg_rd = 1'b1; cfg_sel = s; #1 v = cfg_rdata;
    @(negedge clk); cfg_rd = 1'b0;
  endtask

  task automatic observe(input logic [7:0] src);
    @(negedge clk); mon_valid = 1'b1; mon_src_id = src;
    @(negedge clk); mon_valid = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       exp_flag;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 core_en", core_en, 0);
    chk("R1 tx_join", tx_join, 0);
    chk("R1 rx_mon_en", rx_mon_en, 0);
    rst_n = 1'b1;
    read_now(2'd0, v); chk("R1 node", v, 0);
    read_now(2'd1, v); chk("R1 tent", v, 0);
    read_now(2'd2, v); chk("R1 flag", v, 0);
    // R10 idle and unused sub-address
    @(negedge clk); #1 chk("R10 idle rdata", cfg_rdata, 0);
    read_now(2'd3, v); chk("R10 sel3", v, 0);
    // R2 R3 R4 R5 sweep all node IDs with both tx_enable values
    for (int i = 0; i < 256; i++) begin
      tx_enable = i[0];
      wr_reg(2'd0, 8'(i));
      chk("R3 core_en", core_en, (i != 0) ? 1 : 0);
      chk("R5 rx_mon_en", rx_mon_en, (i != 0) ? 1 : 0);
      chk("R4 tx_join", tx_join, ((i != 0) && i[0]) ? 1 : 0);
      chk("R2 node_id port", node_id, i);
      read_now(2'd0, v); chk("R2 node readback", v, i);
    end
    // R4 tx_join follows tx_enable same cycle
    @(negedge clk); tx_enable = 1'b0; #1 chk("R4 txen drop", tx_join, 0);
    chk("R5 rx stays with txen off", rx_mon_en, 1);
    @(negedge clk); tx_enable = 1'b1; #1 chk("R4 txen rise", tx_join, 1);
    // R2 writes to sel 2/3 touch neither register
    wr_reg(2'd1, 8'h5A);
    wr_reg(2'd2, 8'h11); wr_reg(2'd3, 8'h22);
    read_now(2'd0, v); chk("R2 node kept", v, 8'hFF);
    read_now(2'd1, v); chk("R2 tent kept", v, 8'h5A);
    // R6 sweep tentative IDs: matching and mismatching source
    succ_id = 8'h00;
    for (int t = 0; t < 256; t++) begin
      wr_reg(2'd1, 8'(t));
      read_now(2'd1, v); chk("R2 tent readback", v, t);
      observe(8'(t) ^ 8'h01);
      read_now(2'd2, v); chk("R6 mismatch no set", v, 0);
      observe(8'(t));
      exp_flag = (t != 0);
      read_now(2'd2, v); chk("R6 match sets", v, exp_flag ? 1 : 0);
      read_now(2'd2, v); chk("R7 diag read clears", v, 0);
    end
    // R8 successor source never sets
    wr_reg(2'd1, 8'h33); succ_id = 8'h33;
    observe(8'h33);
    read_now(2'd2, v); chk("R8 succ no set", v, 0);
    succ_id = 8'h44;
    // R7 tentative write wins over same-cycle match
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = 2'd1; cfg_wdata = 8'h33;
    mon_valid = 1'b1; mon_src_id = 8'h33;
    @(negedge clk); cfg_wr = 1'b0; mon_valid = 1'b0;
    read_now(2'd2, v); chk("R7 tent wr wins", v, 0);
    // R7 tentative write clears a set flag
    observe(8'h33);
    wr_reg(2'd1, 8'h33);
    read_now(2'd2, v); chk("R7 tent wr clears", v, 0);
    // R7 match during diag read keeps flag
    observe(8'h33);
    @(negedge clk); cfg_rd = 1'b1; cfg_sel = 2'd2; mon_valid = 1'b1;
    #1 chk("R7 read returns set", cfg_rdata, 1);
    @(negedge clk); cfg_rd = 1'b0; mon_valid = 1'b0;
    read_now(2'd2, v); chk("R7 set wins over read", v, 1);
    // R6 no set while dormant; R9 zero write sleeps
    wr_reg(2'd0, 8'h00);
    chk("R9 core_en", core_en, 0);
    chk("R9 tx_join", tx_join, 0);
    chk("R9 rx_mon_en", rx_mon_en, 0);
    read_now(2'd1, v); chk("R9 tent kept", v, 8'h33);
    observe(8'h33);
    read_now(2'd2, v); chk("R6 dormant no set", v, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule